// File: doc/BRIEF.md
# Keyed Software Watchdog

This block guards a system against software that has stopped making progress. A counter advances on every enabled clock. If software lets it reach the selected timeout, the block requests a system reset and records that the watchdog caused it. Software keeps the counter from expiring by writing a two-byte key to the service location: first 0x55, then 0xAA. A single strobe does not service it.

The watchdog's behaviour is set by one 4-bit control field, which comes from the top nibble of a byte write. That field accepts exactly one write after each reset, so code that runs later cannot turn the watchdog off or lengthen its timeout. A debug freeze input can stop the count, but only when the freeze-permit pin is tied high. The cause flag survives the system reset that the watchdog itself triggers. Only the power-on reset clears it, so boot code can read why the chip restarted.

Top module: `wdog_keyed`

## Requirements
- R1: After `por_n` is released, `rst_req` is 0 and `rst_cause` is 0x00. The control field comes up with the watchdog enabled, prescale off and select 0, so the counter runs from the first clock.
- R2: A control write (`wr_en`=1, `wr_sel`=0) reads bit 7 as enable, bit 6 as prescale and bits 5:4 as select. With prescale off, the timeout is 2^(BASE_LOG2 + STEP_LOG2*select) enabled clocks. The defaults give 2^9, 2^11, 2^13 and 2^15.
- R3: With the prescale bit set, every timeout is multiplied by 2^PRE_LOG2 (default 2^9).
- R4: The first control write after reset is taken and restarts the count. Every later control write is ignored, and does not restart the count, until `rst_n` or `por_n` is asserted again.
- R5: With enable clear, the counter stays at zero and `rst_req` never rises.
- R6: A write of 0x55 to the service location (`wr_sel`=1) arms the key. A following write of 0xAA clears the counter in the cycle it is written. Writing 0x55 again while armed keeps the key armed.
- R7: A write of 0xAA while the key is not armed leaves the counter running. A service write of any value other than 0x55 or 0xAA disarms the key.
- R8: While `freeze`=1 and `frz_allow`=1, the counter holds its value. With `frz_allow`=0, `freeze` has no effect.
- R9: `rst_req` rises on the clock edge that completes the timeout. It stays at 1 until `rst_n` or `por_n` is asserted, and the count stops while it is high.
- R10: At expiry, bit 5 of `rst_cause` is set. The flag is kept through `rst_n` and cleared only by `por_n`. All other `rst_cause` bits read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous; clears everything including the cause flag |
| rst_n | input | 1 | System reset, active low, asynchronous; clears everything except the cause flag |
| wr_en | input | 1 | Byte write strobe |
| wr_sel | input | 1 | Write target: 0 control, 1 service key |
| wr_data | input | 8 | Write data byte |
| freeze | input | 1 | Debug freeze request |
| frz_allow | input | 1 | Lets `freeze` halt the counter |
| rst_req | output | 1 | Sticky system reset request |
| rst_cause | output | 8 | Reset cause byte; bit 5 flags a watchdog expiry |

## Verification
The hardest case to reach is a control write that the lock drops. Such a write changes nothing visible at once, so its only trace is when the reset request fires. The stimulus therefore follows an accepted write with a second write that would disable the watchdog, then times the expiry from the first write. A disarmed or out-of-order key is handled the same way: it is proven harmless by finding expiry at the edge counted from the last genuine restart. Freeze is checked by how far it delays expiry.

// File: rtl/wdog_keyed_pkg.sv
package wdog_keyed_pkg;

   typedef struct packed {
      logic       en;
      logic       pre;
      logic [1:0] sel;
   } wdog_ctrl_t;

   localparam logic [7:0] KEY_ARM   = 8'h55;
   localparam logic [7:0] KEY_FIRE  = 8'hAA;
   localparam logic       SEL_CTRL  = 1'b0;
   localparam logic       SEL_SVC   = 1'b1;
   localparam int         CAUSE_BIT = 5;

endpackage

// File: rtl/wdog_ctrl_lock.sv
module wdog_ctrl_lock
   import wdog_keyed_pkg::*;
#(
   parameter logic [3:0] RST_CTRL = 4'b1000
)(
   input  logic       clk,
   input  logic       rst_all_n,
   input  logic       wr_ctrl,
   input  logic [3:0] wr_nib,
   output wdog_ctrl_t ctrl_q,
   output logic       locked,
   output logic       accept
);

   assign accept = wr_ctrl && !locked;

   always_ff @(posedge clk or negedge rst_all_n) begin
      if (!rst_all_n) begin
         ctrl_q <= wdog_ctrl_t'(RST_CTRL);
         locked <= 1'b0;
      end else if (accept) begin
         ctrl_q <= wdog_ctrl_t'(wr_nib);
         locked <= 1'b1;
      end
   end

endmodule

// File: rtl/wdog_key_seq.sv
module wdog_key_seq
   import wdog_keyed_pkg::*;
(
   input  logic       clk,
   input  logic       rst_all_n,
   input  logic       wr_svc,
   input  logic [7:0] wr_data,
   output logic       done,
   output logic       armed
);

   assign done = wr_svc && armed && (wr_data == KEY_FIRE);

   always_ff @(posedge clk or negedge rst_all_n) begin
      if (!rst_all_n)
         armed <= 1'b0;
      else if (wr_svc)
         armed <= (wr_data == KEY_ARM);
   end

endmodule

// File: rtl/wdog_timebase.sv
module wdog_timebase
   import wdog_keyed_pkg::*;
#(
   parameter int BASE_LOG2 = 9,
   parameter int STEP_LOG2 = 2,
   parameter int PRE_LOG2  = 9,
   localparam int MAIN_W   = BASE_LOG2 + 3 * STEP_LOG2
)(
   input  logic              clk,
   input  logic              rst_all_n,
   input  wdog_ctrl_t        ctrl,
   input  logic              restart,
   input  logic              hold,
   output logic              expire,
   output logic [MAIN_W-1:0] count
);

   localparam logic [MAIN_W-1:0] ONE = MAIN_W'(1);

   logic              run;
   logic              tick;
   logic [MAIN_W-1:0] lim;
   int                sh;

   assign run = ctrl.en && !hold;

   generate
      if (PRE_LOG2 > 0) begin : g_pre
         logic [PRE_LOG2-1:0] div;
         always_ff @(posedge clk or negedge rst_all_n) begin
            if (!rst_all_n)
               div <= '0;
            else if (!ctrl.en || restart)
               div <= '0;
            else if (run && ctrl.pre)
               div <= div + 1'b1;
         end
         assign tick = run && (!ctrl.pre || (&div));
      end else begin : g_nopre
         assign tick = run;
      end
   endgenerate

   always_comb begin
      sh  = BASE_LOG2 + int'(ctrl.sel) * STEP_LOG2;
      lim = (ONE << sh) - ONE;
   end

   assign expire = tick && !restart && (count == lim);

   always_ff @(posedge clk or negedge rst_all_n) begin
      if (!rst_all_n)
         count <= '0;
      else if (!ctrl.en || restart || expire)
         count <= '0;
      else if (tick)
         count <= count + ONE;
   end

endmodule

// File: rtl/wdog_keyed.sv
module wdog_keyed
   import wdog_keyed_pkg::*;
#(
   parameter int         BASE_LOG2 = 9,
   parameter int         STEP_LOG2 = 2,
   parameter int         PRE_LOG2  = 9,
   parameter logic [3:0] RST_CTRL  = 4'b1000
)(
   input  logic       clk,
   input  logic       por_n,
   input  logic       rst_n,
   input  logic       wr_en,
   input  logic       wr_sel,
   input  logic [7:0] wr_data,
   input  logic       freeze,
   input  logic       frz_allow,
   output logic       rst_req,
   output logic [7:0] rst_cause
);

   localparam int MAIN_W = BASE_LOG2 + 3 * STEP_LOG2;

   generate
      if (BASE_LOG2 < 1) begin : g_bad_base
         $error("wdog_keyed: BASE_LOG2 must be at least 1");
      end
      if (STEP_LOG2 < 1) begin : g_bad_step
         $error("wdog_keyed: STEP_LOG2 must be at least 1");
      end
      if (PRE_LOG2 < 0) begin : g_bad_pre
         $error("wdog_keyed: PRE_LOG2 must not be negative");
      end
      if (MAIN_W > 30) begin : g_bad_width
         $error("wdog_keyed: timeout range too wide");
      end
   endgenerate

   logic              rst_all_n;
   wdog_ctrl_t        ctrl_q;
   logic              ctrl_locked;
   logic              ctrl_accept;
   logic              svc_done;
   logic              key_armed;
   logic              expire;
   logic              hold;
   logic              cause_q;
   logic [MAIN_W-1:0] count;

   assign rst_all_n = rst_n && por_n;
   assign hold      = (freeze && frz_allow) || rst_req;

   wdog_ctrl_lock #(.RST_CTRL(RST_CTRL)) u_lock (
      .clk       (clk),
      .rst_all_n (rst_all_n),
      .wr_ctrl   (wr_en && (wr_sel == SEL_CTRL)),
      .wr_nib    (wr_data[7:4]),
      .ctrl_q    (ctrl_q),
      .locked    (ctrl_locked),
      .accept    (ctrl_accept)
   );

   wdog_key_seq u_key (
      .clk       (clk),
      .rst_all_n (rst_all_n),
      .wr_svc    (wr_en && (wr_sel == SEL_SVC)),
      .wr_data   (wr_data),
      .done      (svc_done),
      .armed     (key_armed)
   );

   wdog_timebase #(
      .BASE_LOG2 (BASE_LOG2),
      .STEP_LOG2 (STEP_LOG2),
      .PRE_LOG2  (PRE_LOG2)
   ) u_tb (
      .clk       (clk),
      .rst_all_n (rst_all_n),
      .ctrl      (ctrl_q),
      .restart   (ctrl_accept || svc_done),
      .hold      (hold),
      .expire    (expire),
      .count     (count)
   );

   always_ff @(posedge clk or negedge rst_all_n) begin
      if (!rst_all_n)
         rst_req <= 1'b0;
      else if (expire)
         rst_req <= 1'b1;
   end

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n)
         cause_q <= 1'b0;
      else if (expire)
         cause_q <= 1'b1;
   end

   always_comb begin
      rst_cause            = '0;
      rst_cause[CAUSE_BIT] = cause_q;
   end

endmodule

// File: rtl/wdog_keyed_chk.sv
module wdog_keyed_chk #(
   parameter int CNT_W = 15
)(
   input logic             clk,
   input logic             por_n,
   input logic             rst_n,
   input logic             wr_en,
   input logic             wr_sel,
   input logic             freeze,
   input logic             frz_allow,
   input logic             rst_req,
   input logic [7:0]       rst_cause,
   input logic [3:0]       ctrl_bits,
   input logic             ctrl_locked,
   input logic             ctrl_accept,
   input logic             svc_done,
   input logic [CNT_W-1:0] count
);

   logic sys_ok;
   assign sys_ok = rst_n && por_n;

   assert_lock_hold_R4: assert property (@(posedge clk) disable iff (!sys_ok)
      (ctrl_locked && wr_en && !wr_sel) |=> $stable(ctrl_bits));

   assert_idle_zero_R5: assert property (@(posedge clk) disable iff (!sys_ok)
      !ctrl_bits[3] |-> (count == '0) && !$rose(rst_req));

   assert_service_clear_R6: assert property (@(posedge clk) disable iff (!sys_ok)
      svc_done |=> (count == '0));

   assert_freeze_hold_R8: assert property (@(posedge clk) disable iff (!sys_ok)
      (freeze && frz_allow && !ctrl_accept && !svc_done) |=> $stable(count));

   assert_req_sticky_R9: assert property (@(posedge clk) disable iff (!sys_ok)
      rst_req |=> rst_req);

   assert_req_cause_R10: assert property (@(posedge clk) disable iff (!sys_ok)
      rst_req |-> rst_cause[5]);

   assert_cause_sticky_R10: assert property (@(posedge clk) disable iff (!por_n)
      rst_cause[5] |=> rst_cause[5]);

   assert_cause_bits_R10: assert property (@(posedge clk) disable iff (!por_n)
      (rst_cause & 8'hDF) == 8'h00);

endmodule

bind wdog_keyed wdog_keyed_chk #(.CNT_W(MAIN_W)) u_chk (
   .clk         (clk),
   .por_n       (por_n),
   .rst_n       (rst_n),
   .wr_en       (wr_en),
   .wr_sel      (wr_sel),
   .freeze      (freeze),
   .frz_allow   (frz_allow),
   .rst_req     (rst_req),
   .rst_cause   (rst_cause),
   .ctrl_bits   (ctrl_q),
   .ctrl_locked (ctrl_locked),
   .ctrl_accept (ctrl_accept),
   .svc_done    (svc_done),
   .count       (count)
);

// File: tb/wdog_keyed_test.sv
`timescale 1ns/1ps
module wdog_keyed_test;

   localparam int BASE = 4;
   localparam int STEP = 2;
   localparam int PRE  = 3;

   typedef struct packed {
      logic [7:0]  ctrl;
      logic [31:0] len;
   } vec_t;

   localparam vec_t VECS [6] = '{
      '{ctrl: 8'h80, len: 32'd16},
      '{ctrl: 8'h90, len: 32'd64},
      '{ctrl: 8'hA0, len: 32'd256},
      '{ctrl: 8'hB0, len: 32'd1024},
      '{ctrl: 8'hC0, len: 32'd128},
      '{ctrl: 8'hD0, len: 32'd512}
   };

   logic       clk = 1'b0;
   logic       por_n, rst_n, wr_en, wr_sel, freeze, frz_allow;
   logic [7:0] wr_data;
   logic       rst_req;
   logic [7:0] rst_cause;

   int n_chk  = 0;
   int n_fail = 0;

   always #5 clk = ~clk;

   wdog_keyed #(.BASE_LOG2(BASE), .STEP_LOG2(STEP), .PRE_LOG2(PRE)) uut (
      .clk       (clk),
      .por_n     (por_n),
      .rst_n     (rst_n),
      .wr_en     (wr_en),
      .wr_sel    (wr_sel),
      .wr_data   (wr_data),
      .freeze    (freeze),
      .frz_allow (frz_allow),
      .rst_req   (rst_req),
      .rst_cause (rst_cause)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   // entered at a negedge; returns at the negedge after the sampling edge
   task automatic wr(input logic sel, input logic [7:0] d);
      wr_en = 1'b1; wr_sel = sel; wr_data = d;
      @(posedge clk); @(negedge clk);
      wr_en = 1'b0; wr_data = 8'h00;
   endtask

   task automatic por_pulse();
      por_n = 1'b0; rst_n = 1'b0;
      @(posedge clk); @(negedge clk);
      por_n = 1'b1; rst_n = 1'b1;
   endtask

   task automatic sys_pulse();
      rst_n = 1'b0;
      @(posedge clk); @(negedge clk);
      rst_n = 1'b1;
   endtask

   // expiry must land exactly 'remain' edges from now
   task automatic check_expire(input int remain, input string tag);
      repeat (remain - 1) @(posedge clk);
      @(negedge clk);
      chk({tag, " not yet"}, rst_req, 1'b0);
      @(posedge clk); @(negedge clk);
      chk({tag, " expired"}, rst_req, 1'b1);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
   end

   initial begin
      por_n = 1'b0; rst_n = 1'b0; wr_en = 1'b0; wr_sel = 1'b0;
      wr_data = 8'h00; freeze = 1'b0; frz_allow = 1'b0;
      @(negedge clk); @(negedge clk);
      chk("R1 reset req", rst_req, 1'b0);
      chk("R1 reset cause", rst_cause, 8'h00);
      por_n = 1'b1; rst_n = 1'b1;
      check_expire(16, "R1 default enabled sel0");
      chk("R10 cause set", rst_cause, 8'h20);

      // vector table: R2 select values, R3 prescale
      foreach (VECS[i]) begin
         por_pulse();
         wr(1'b0, VECS[i].ctrl);
         check_expire(int'(VECS[i].len), $sformatf("R2/R3 ctrl %0h", VECS[i].ctrl));
         chk("R10 cause after vector", rst_cause, 8'h20);
      end

      // R9 sticky request, R10 cause kept through rst_n
      repeat (40) @(posedge clk);
      @(negedge clk);
      chk("R9 request sticky", rst_req, 1'b1);
      sys_pulse();
      chk("R9 request cleared by rst_n", rst_req, 1'b0);
      chk("R10 cause kept over rst_n", rst_cause, 8'h20);
      por_pulse();
      chk("R10 cause cleared by por_n", rst_cause, 8'h00);

      // R4 lock: second write must not restart nor disable
      wr(1'b0, 8'h90);
      wr(1'b0, 8'h00);
      check_expire(63, "R4 second write ignored");

      // R5 disabled, then lock keeps it disabled
      por_pulse();
      wr(1'b0, 8'h00);
      repeat (1500) @(posedge clk);
      @(negedge clk);
      chk("R5 disabled no request", rst_req, 1'b0);
      wr(1'b0, 8'h80);
      repeat (100) @(posedge clk);
      @(negedge clk);
      chk("R4 locked while disabled", rst_req, 1'b0);

      // R6 proper service
      por_pulse();
      wr(1'b0, 8'h90);
      repeat (30) @(posedge clk);
      @(negedge clk);
      wr(1'b1, 8'h55);
      wr(1'b1, 8'hAA);
      check_expire(64, "R6 key restarts");

      // R6 repeated arm key
      por_pulse();
      wr(1'b0, 8'h90);
      repeat (20) @(posedge clk);
      @(negedge clk);
      wr(1'b1, 8'h55);
      wr(1'b1, 8'h55);
      wr(1'b1, 8'hAA);
      check_expire(64, "R6 repeated arm");

      // R7 lone second key
      por_pulse();
      wr(1'b0, 8'h90);
      repeat (10) @(posedge clk);
      @(negedge clk);
      wr(1'b1, 8'hAA);
      check_expire(53, "R7 lone 0xAA");

      // R7 foreign value disarms
      por_pulse();
      wr(1'b0, 8'h90);
      wr(1'b1, 8'h55);
      wr(1'b1, 8'h12);
      wr(1'b1, 8'hAA);
      check_expire(61, "R7 disarmed by other value");

      // R8 freeze honoured
      por_pulse();
      frz_allow = 1'b1;
      wr(1'b0, 8'h90);
      freeze = 1'b1;
      repeat (20) @(posedge clk);
      @(negedge clk);
      freeze = 1'b0;
      check_expire(64, "R8 freeze holds");

      // R8 freeze not permitted
      por_pulse();
      frz_allow = 1'b0;
      wr(1'b0, 8'h90);
      freeze = 1'b1;
      repeat (20) @(posedge clk);
      @(negedge clk);
      freeze = 1'b0;
      check_expire(44, "R8 freeze ignored");

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
   end

endmodule